// File: doc/BRIEF.md
# Power No-Load Creep Suppressor

This block sits between a power multiplier and an energy accumulator. It keeps a meter from creeping, that is, from slowly building up energy when no load is connected. Each valid power sample is compared by magnitude against a no-load level. That level is a fixed fraction of the multiplier's full-scale output, and a 2-bit mode code picks the fraction. A sample that falls below the level goes downstream as zero, so nothing is accumulated for it. The same detection sets a sticky status flag, and the flag can raise an interrupt request.

An RMS current stream can be sent through the same gate with a select input. It uses the same level as the power path. The software side reaches the block only through plain level inputs and a one-cycle flag-clear strobe.

Top module: `noload_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_vld`, `out_pwr`, `rms_out_vld`, `rms_out_val`, `nl_flag` and `irq` are all 0.
- R2: With `nl_mode` = 2'b00, detection is off. Every valid power sample reaches `out_pwr` unchanged, whatever its size, and `nl_flag` is never set.
- R3: With the default full scale of 16777215, the threshold is 5033 for mode 2'b01, 2517 for mode 2'b10 and 1258 for mode 2'b11. A valid sample whose magnitude is strictly below the threshold gives `out_pwr` = 0. A magnitude equal to or above the threshold passes unchanged.
- R4: `smp_pwr` is two's-complement signed. The comparison uses its absolute value, and the most negative code counts as a large magnitude.
- R5: `out_vld` repeats `smp_vld` one clock later. `out_pwr` belongs to the sample presented one clock earlier.
- R6: A cycle with `smp_vld` low never sets `nl_flag`, whatever the value on `smp_pwr`.
- R7: A valid below-threshold sample sets `nl_flag` on the next clock. The flag stays set through later above-threshold samples until a `flag_clr` pulse clears it.
- R8: If `flag_clr` arrives in the same cycle as a new valid below-threshold sample, `nl_flag` stays set.
- R9: `irq` is high exactly when `nl_flag` is high and `irq_en` was high on the same clock edge that updated `nl_flag`. It drops when the flag is cleared or the enable is removed.
- R10: With `rms_sel` = 1 and a nonzero mode, an `rms_val` strictly below the R3 threshold gives `rms_out_val` = 0. Otherwise `rms_out_val` repeats `rms_val` one clock later, and `rms_out_vld` repeats `rms_vld`. The RMS path never changes `nl_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Power sample strobe |
| smp_pwr | input | PW (25) | Signed power sample |
| rms_vld | input | 1 | RMS current sample strobe |
| rms_val | input | FSW (24) | Unsigned RMS current value |
| nl_mode | input | 2 | Threshold code: 00 off, 01/10/11 high/mid/low |
| rms_sel | input | 1 | Apply the threshold to the RMS path |
| irq_en | input | 1 | No-load interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| out_vld | output | 1 | Gated power strobe |
| out_pwr | output | PW (25) | Gated power sample, zero when suppressed |
| rms_out_vld | output | 1 | Gated RMS strobe |
| rms_out_val | output | FSW (24) | Gated RMS value, zero when suppressed |
| nl_flag | output | 1 | Sticky no-load status |
| irq | output | 1 | Interrupt request |

## Verification
A wrong threshold or a wrong magnitude computation shows up one clock after the faulty sample: a value next to the threshold either comes out as zero when it should pass, or passes when it should be zero. Flag faults, such as a lost set, a clear that wins a collision, or a flag set by an invalid cycle, appear on `nl_flag` and `irq` at the next edge. Once wrong, they stay visible until the following clear. The tests therefore probe both sides of every threshold, each sign, and each ordering of clear against detection.

// File: rtl/nlg_pkg.sv
package nlg_pkg;

  // Threshold selection codes; higher code halves the level
  typedef enum logic [1:0] {
    NL_OFF = 2'b00,
    NL_HI  = 2'b01,
    NL_MID = 2'b10,
    NL_LO  = 2'b11
  } nl_mode_e;

  // Nearest-integer scaled fraction of full scale
  function automatic longint unsigned nl_round(input longint unsigned fs,
                                               input longint unsigned num,
                                               input longint unsigned den);
    return (fs * num + den / 2) / den;
  endfunction

endpackage

// File: rtl/nlg_thresh.sv
module nlg_thresh #(
  parameter int              FSW = 24,
  parameter longint unsigned FS  = 64'd16777215
) (
  input  logic [1:0]     mode,
  output logic [FSW-1:0] thr,
  output logic           active
);
  import nlg_pkg::*;

  localparam longint unsigned T_HI  = nl_round(FS, 64'd3, 64'd10000);
  localparam longint unsigned T_MID = nl_round(FS, 64'd3, 64'd20000);
  localparam longint unsigned T_LO  = nl_round(FS, 64'd3, 64'd40000);

  localparam logic [FSW-1:0] THR_HI  = T_HI[FSW-1:0];
  localparam logic [FSW-1:0] THR_MID = T_MID[FSW-1:0];
  localparam logic [FSW-1:0] THR_LO  = T_LO[FSW-1:0];

  always_comb begin
    active = 1'b1;
    case (mode)
      NL_HI:   thr = THR_HI;
      NL_MID:  thr = THR_MID;
      NL_LO:   thr = THR_LO;
      default: begin
        thr    = '0;
        active = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nlg_cmp.sv
module nlg_cmp #(
  parameter int IW        = 25,
  parameter int MW        = 24,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic          vld,
  input  logic [IW-1:0] data,
  input  logic [MW-1:0] thr,
  input  logic          active,
  output logic          below
);
  localparam int CW = (IW > MW) ? IW : MW;

  logic [IW-1:0] mag;

  generate
    if (SIGNED_IN) begin : g_abs
      always_comb mag = data[IW-1] ? (~data + 1'b1) : data;
    end else begin : g_raw
      always_comb mag = data;
    end
  endgenerate

  logic [CW-1:0] mag_x;
  logic [CW-1:0] thr_x;

  always_comb begin
    mag_x = CW'(mag);
    thr_x = CW'(thr);
    below = vld && active && (mag_x < thr_x);
  end

endmodule

// File: rtl/nlg_stage.sv
module nlg_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  input  logic         drop,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= in_vld;
      out_data <= (in_vld && !drop) ? in_data : '0;
    end
  end

endmodule

// File: rtl/nlg_flag.sv
module nlg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  // set beats clear when both arrive together
  always_comb flag_nxt = set || (flag && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt && irq_en;
    end
  end

endmodule

// File: rtl/noload_gate.sv
module noload_gate #(
  parameter int              FSW = 24,
  parameter int              PW  = FSW + 1,
  parameter longint unsigned FS  = (64'd1 << FSW) - 64'd1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_vld,
  input  logic [PW-1:0]  smp_pwr,
  input  logic           rms_vld,
  input  logic [FSW-1:0] rms_val,
  input  logic [1:0]     nl_mode,
  input  logic           rms_sel,
  input  logic           irq_en,
  input  logic           flag_clr,
  output logic           out_vld,
  output logic [PW-1:0]  out_pwr,
  output logic           rms_out_vld,
  output logic [FSW-1:0] rms_out_val,
  output logic           nl_flag,
  output logic           irq
);
  logic [FSW-1:0] thr;
  logic           thr_on;
  logic           pwr_below;
  logic           rms_below;
  logic           rms_gate_on;

  nlg_thresh #(.FSW(FSW), .FS(FS)) u_thr (
    .mode   (nl_mode),
    .thr    (thr),
    .active (thr_on)
  );

  nlg_cmp #(.IW(PW), .MW(FSW), .SIGNED_IN(1'b1)) u_cmp_pwr (
    .vld    (smp_vld),
    .data   (smp_pwr),
    .thr    (thr),
    .active (thr_on),
    .below  (pwr_below)
  );

  always_comb rms_gate_on = thr_on && rms_sel;

  nlg_cmp #(.IW(FSW), .MW(FSW), .SIGNED_IN(1'b0)) u_cmp_rms (
    .vld    (rms_vld),
    .data   (rms_val),
    .thr    (thr),
    .active (rms_gate_on),
    .below  (rms_below)
  );

  nlg_stage #(.W(PW)) u_stg_pwr (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (smp_vld),
    .in_data  (smp_pwr),
    .drop     (pwr_below),
    .out_vld  (out_vld),
    .out_data (out_pwr)
  );

  nlg_stage #(.W(FSW)) u_stg_rms (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (rms_vld),
    .in_data  (rms_val),
    .drop     (rms_below),
    .out_vld  (rms_out_vld),
    .out_data (rms_out_val)
  );

  nlg_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (pwr_below),
    .clr    (flag_clr),
    .irq_en (irq_en),
    .flag   (nl_flag),
    .irq    (irq)
  );

endmodule

// File: rtl/nlg_chk.sv
module nlg_chk #(
  parameter int PW = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld,
  input logic [PW-1:0] smp_pwr,
  input logic [1:0]    nl_mode,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          out_vld,
  input logic [PW-1:0] out_pwr,
  input logic          nl_flag,
  input logic          irq
);
  // R1: reset clears status
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!nl_flag && !irq && !out_vld));

  // R2: detection off passes samples untouched
  p_off_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && nl_mode == 2'b00) |=> (out_pwr == $past(smp_pwr)));

  // R5: strobe delayed by one clock
  p_vld_follow_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_vld == $past(smp_vld)));

  // R6: invalid cycles never set the flag
  p_no_set_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !nl_flag) |=> !nl_flag);

  // R7: flag is sticky without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (nl_flag && !flag_clr) |=> nl_flag);

  // R7: clear with no detection empties the flag
  p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !smp_vld) |=> !nl_flag);

  // R9: request follows flag gated by enable
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (nl_flag && $past(irq_en))));

endmodule

bind noload_gate nlg_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .smp_pwr  (smp_pwr),
  .nl_mode  (nl_mode),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .out_vld  (out_vld),
  .out_pwr  (out_pwr),
  .nl_flag  (nl_flag),
  .irq      (irq)
);

// File: tb/sim_noload_gate.sv
module sim_noload_gate;
  localparam int FSW = 24;
  localparam int PW  = 25;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_vld = 1'b0;
  logic signed [PW-1:0] smp_pwr = '0;
  logic                 rms_vld = 1'b0;
  logic [FSW-1:0]       rms_val = '0;
  logic [1:0]           nl_mode = 2'b00;
  logic                 rms_sel = 1'b0;
  logic                 irq_en = 1'b0;
  logic                 flag_clr = 1'b0;
  logic                 out_vld;
  logic signed [PW-1:0] out_pwr;
  logic                 rms_out_vld;
  logic [FSW-1:0]       rms_out_val;
  logic                 nl_flag;
  logic                 irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  noload_gate u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
    .rms_vld(rms_vld), .rms_val(rms_val), .nl_mode(nl_mode),
    .rms_sel(rms_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .out_vld(out_vld), .out_pwr(out_pwr), .rms_out_vld(rms_out_vld),
    .rms_out_val(rms_out_val), .nl_flag(nl_flag), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one clock with a power sample, optional clear; results read after the edge
  task automatic put(input logic v, input longint p, input logic clr);
    @(negedge clk);
    smp_vld  = v;
    smp_pwr  = p[PW-1:0];
    flag_clr = clr;
    @(posedge clk);
    #1;
    smp_vld  = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic rput(input longint r);
    @(negedge clk);
    rms_vld = 1'b1;
    rms_val = r[FSW-1:0];
    @(posedge clk);
    #1;
    rms_vld = 1'b0;
  endtask

  task automatic clear_flag();
    put(1'b0, 0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 out_vld", longint'(out_vld), 0);
    chk("R1 out_pwr", longint'(out_pwr), 0);
    chk("R1 rms_out_vld", longint'(rms_out_vld), 0);
    chk("R1 rms_out_val", longint'(rms_out_val), 0);
    chk("R1 nl_flag", longint'(nl_flag), 0);
    chk("R1 irq", longint'(irq), 0);
  endtask

  task automatic t_mode_off();
    nl_mode = 2'b00;
    put(1'b1, 0, 1'b0);      chk("R2 zero", longint'(out_pwr), 0);
    put(1'b1, 5, 1'b0);      chk("R2 small", longint'(out_pwr), 5);
    put(1'b1, -3, 1'b0);     chk("R2 neg", longint'(out_pwr), -3);
    put(1'b1, 100000, 1'b0); chk("R2 big", longint'(out_pwr), 100000);
    chk("R2 flag", longint'(nl_flag), 0);
  endtask

  task automatic t_thresholds();
    longint th[3] = '{5033, 2517, 1258};
    for (int m = 1; m <= 3; m++) begin
      nl_mode = m[1:0];
      put(1'b1, th[m-1] - 1, 1'b0);
      chk("R3 below", longint'(out_pwr), 0);
      put(1'b1, th[m-1], 1'b0);
      chk("R3 at", longint'(out_pwr), th[m-1]);
      clear_flag();
    end
    nl_mode = 2'b10;
    put(1'b1, 2600, 1'b0);
    chk("R3 mid passes 2600", longint'(out_pwr), 2600);
  endtask

  task automatic t_negative();
    nl_mode = 2'b01;
    put(1'b1, -5032, 1'b0); chk("R4 neg below", longint'(out_pwr), 0);
    put(1'b1, -5033, 1'b0); chk("R4 neg at", longint'(out_pwr), -5033);
    put(1'b1, -(64'sd1 <<< 24), 1'b0);
    chk("R4 most negative", longint'(out_pwr), -(64'sd1 <<< 24));
    clear_flag();
  endtask

  task automatic t_latency();
    nl_mode = 2'b01;
    put(1'b1, 9000, 1'b0); chk("R5 vld high", longint'(out_vld), 1);
    chk("R5 data", longint'(out_pwr), 9000);
    put(1'b0, 9000, 1'b0); chk("R5 vld low", longint'(out_vld), 0);
  endtask

  task automatic t_invalid();
    nl_mode = 2'b01;
    clear_flag();
    put(1'b0, 1, 1'b0);
    put(1'b0, -1, 1'b0);
    chk("R6 flag idle", longint'(nl_flag), 0);
  endtask

  task automatic t_sticky();
    nl_mode = 2'b11;
    put(1'b1, 10, 1'b0);    chk("R7 set", longint'(nl_flag), 1);
    put(1'b1, 50000, 1'b0);
    put(1'b1, -50000, 1'b0); chk("R7 held", longint'(nl_flag), 1);
    clear_flag();            chk("R7 cleared", longint'(nl_flag), 0);
  endtask

  task automatic t_collide();
    nl_mode = 2'b01;
    put(1'b1, 7, 1'b0);
    put(1'b1, 7, 1'b1);      chk("R8 clr with detect", longint'(nl_flag), 1);
    put(1'b1, 9999, 1'b1);   chk("R8 clr with pass", longint'(nl_flag), 0);
  endtask

  task automatic t_irq();
    nl_mode = 2'b01;
    irq_en = 1'b0;
    put(1'b1, 1, 1'b0);      chk("R9 masked", longint'(irq), 0);
    @(negedge clk); irq_en = 1'b1;
    @(posedge clk); #1;      chk("R9 raised", longint'(irq), 1);
    put(1'b1, 9999, 1'b0);   chk("R9 kept", longint'(irq), 1);
    clear_flag();            chk("R9 dropped", longint'(irq), 0);
    put(1'b1, 1, 1'b0);      chk("R9 again", longint'(irq), 1);
    @(negedge clk); irq_en = 1'b0;
    @(posedge clk); #1;      chk("R9 disabled", longint'(irq), 0);
    clear_flag();
  endtask

  task automatic t_rms();
    nl_mode = 2'b01;
    rms_sel = 1'b1;
    rput(5032); chk("R10 below", longint'(rms_out_val), 0);
    chk("R10 vld", longint'(rms_out_vld), 1);
    rput(5033); chk("R10 at", longint'(rms_out_val), 5033);
    chk("R10 no flag", longint'(nl_flag), 0);
    rms_sel = 1'b0;
    rput(5);    chk("R10 unselected", longint'(rms_out_val), 5);
    rms_sel = 1'b1;
    nl_mode = 2'b00;
    rput(5);    chk("R10 mode off", longint'(rms_out_val), 5);
    rms_sel = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_mode_off();
    t_thresholds();
    t_negative();
    t_latency();
    t_invalid();
    t_sticky();
    t_collide();
    t_irq();
    t_rms();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule